// File: doc/BRIEF.md
# Byte-Stream Packet Framer with Checksum Trailer

The framer turns a packet descriptor and a byte payload into a single serialized byte stream. A descriptor supplies a version byte, a type byte and a 16-bit payload length. The block sends a four-byte header and then zero-valued alignment filler, so that the payload begins on an `ALIGN_BYTES` boundary. It then forwards the payload bytes unchanged and closes the packet with a checksum trailer. The checksum is computed over every byte sent before the trailer, filler included. Bit 7 of the type byte selects the trailer. When the bit is clear the packet is a data packet with a 32-bit Castagnoli CRC. When the bit is set it is a control packet with a 16-bit CCITT-style CRC.

Each output byte passes through the CRC on the cycle it is accepted downstream, so the trailer is ready as soon as the last payload byte has left. Downstream backpressure stalls both the output and the payload input. The control path is a five-state machine. `ST_IDLE` waits for a descriptor and takes it on handshake (IDLE→HDR). `ST_HDR` emits the four header bytes. It moves to `ST_PAD` when filler is needed, to `ST_PAY` when the length is non-zero, and otherwise to `ST_TRL`. `ST_PAD` emits the filler and then moves to PAY, or to TRL when the length is zero. `ST_PAY` forwards the payload and moves to TRL after the last byte. `ST_TRL` emits the trailer and returns to IDLE after the final byte has transferred.

Top module: `pkt_framer`

## Requirements
- R1: After reset `desc_ready` is 1, while `out_valid`, `out_last` and `in_ready` are 0.
- R2: The header is sent as four bytes in this order: the version byte, the type byte, length bits 15:8, then length bits 7:0.
- R3: After the header the block sends `(ALIGN_BYTES - 4 % ALIGN_BYTES) % ALIGN_BYTES` filler bytes of value 0x00.
- R4: Exactly `desc_len` payload bytes follow the filler, in arrival order. A length of 0 goes straight from header or filler to the trailer.
- R5: When type bit 7 is 0, the trailer is 4 bytes of CRC-32C, least significant byte first. The CRC is computed LSB-first with the reflected constant 0x82F63B78, preset to 0xFFFFFFFF and inverted at the end. It covers header, filler and payload.
- R6: When type bit 7 is 1, the trailer is 2 bytes of CRC, least significant byte first. The CRC uses the reflected constant 0x8408, is preset to 0xFFFF and is inverted at the end. It covers the same bytes as in R5.
- R7: `out_last` is 1 only on the final trailer byte.
- R8: While `out_ready` is 0, `in_ready` is 0. Outside the payload phase, a stalled output byte stays valid and unchanged.
- R9: `desc_ready` is 1 only when idle. It is 0 from the cycle after a descriptor is taken until the final trailer byte has transferred, and it is 1 again on the next cycle.
- R10: `in_ready` is 0 during the header, filler and trailer phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted when high with desc_valid |
| desc_version | input | 8 | Version byte |
| desc_type | input | 8 | Type byte; bit 7 selects control packet |
| desc_len | input | 16 | Payload length in bytes |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Payload byte taken |
| in_data | input | 8 | Payload byte |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Serialized byte |
| out_last | output | 1 | Final byte of the packet |

## Verification
A wrong byte counter, or a wrong transition out of HDR or PAD, shows up at once as a misplaced header, filler or payload byte on the next accepted output. A CRC register that misses an update, or takes the same byte twice, is only visible at the trailer. That is the first trailer byte of that packet, so the bench compares every trailer byte against a model that it computes itself. A state machine that leaves TRL too early or too late shows up as `out_last` on the wrong byte, or as `desc_ready` coming back at the wrong time. The bench checks both of these on every packet, under random stalls on both sides.

// File: rtl/framer_pkg.sv
package framer_pkg;

    localparam int HDR_BYTES = 4;
    localparam int LEN_W     = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAD,
        ST_PAY,
        ST_TRL
    } frm_state_t;

    // Reflected Castagnoli step, one byte, LSB first
    function automatic logic [31:0] crc32c_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ 32'h82F6_3B78) : (r >> 1);
        end
        return r;
    endfunction

    // Reflected CCITT step, one byte, LSB first
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/framer_crc.sv
module framer_crc
    import framer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [31:0] crc32_fin,
    output logic [15:0] crc16_fin
);

    logic [31:0] crc32_q;
    logic [15:0] crc16_q;

    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            crc32_q <= 32'hFFFF_FFFF;
            crc16_q <= 16'hFFFF;
        end else if (upd) begin
            crc32_q <= crc32c_step(crc32_q, din);
            crc16_q <= crc16_step(crc16_q, din);
        end
    end

    assign crc32_fin = ~crc32_q;
    assign crc16_fin = ~crc16_q;

    // R5/R6: preset to all ones after a descriptor is taken
    a_r5_crc_preset: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (crc32_q == 32'hFFFF_FFFF) && (crc16_q == 16'hFFFF));

    // R5/R6: no accepted byte, no change
    a_r5_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !upd) |=> ($stable(crc32_q) && $stable(crc16_q)));

endmodule

// File: rtl/framer_ctrl.sv
module framer_ctrl
    import framer_pkg::*;
#(
    parameter int ALIGN_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_valid,
    input  logic [7:0]       desc_version,
    input  logic [7:0]       desc_type,
    input  logic [LEN_W-1:0] desc_len,
    output logic             desc_ready,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    input  logic [31:0]      crc32_fin,
    input  logic [15:0]      crc16_fin,
    output logic             crc_init,
    output logic             crc_upd
);

    localparam int PAD_BYTES = (ALIGN_BYTES - (HDR_BYTES % ALIGN_BYTES)) % ALIGN_BYTES;

    frm_state_t       state;
    logic [LEN_W-1:0] cnt;
    logic [7:0]       ver_q, type_q;
    logic [LEN_W-1:0] len_q;
    logic             fire;
    logic             is_ctrl;
    logic [LEN_W-1:0] trl_last;
    frm_state_t       after_hdr;
    frm_state_t       after_pad;

    assign fire     = out_valid && out_ready;
    assign is_ctrl  = type_q[7];
    assign trl_last = is_ctrl ? LEN_W'(1) : LEN_W'(3);
    assign after_pad = (len_q == '0) ? ST_TRL : ST_PAY;

    generate
        if (PAD_BYTES > 0) begin : g_pad
            assign after_hdr = ST_PAD;
        end else begin : g_nopad
            assign after_hdr = after_pad;
        end
    endgenerate

    // State register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            ver_q  <= '0;
            type_q <= '0;
            len_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (desc_valid) begin
                    ver_q  <= desc_version;
                    type_q <= desc_type;
                    len_q  <= desc_len;
                    cnt    <= '0;
                    state  <= ST_HDR;
                end
                ST_HDR: if (fire) begin
                    if (cnt == LEN_W'(HDR_BYTES - 1)) begin
                        cnt   <= '0;
                        state <= after_hdr;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAD: if (fire) begin
                    if (cnt == LEN_W'(PAD_BYTES - 1)) begin
                        cnt   <= '0;
                        state <= after_pad;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAY: if (fire) begin
                    if (cnt == len_q - 1'b1) begin
                        cnt   <= '0;
                        state <= ST_TRL;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_TRL: if (fire) begin
                    if (cnt == trl_last) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        desc_ready = 1'b0;
        in_ready   = 1'b0;
        out_valid  = 1'b0;
        out_data   = 8'h00;
        out_last   = 1'b0;
        unique case (state)
            ST_IDLE: desc_ready = 1'b1;
            ST_HDR: begin
                out_valid = 1'b1;
                unique case (cnt[1:0])
                    2'd0: out_data = ver_q;
                    2'd1: out_data = type_q;
                    2'd2: out_data = len_q[15:8];
                    default: out_data = len_q[7:0];
                endcase
            end
            ST_PAD: out_valid = 1'b1;
            ST_PAY: begin
                out_valid = in_valid;
                in_ready  = out_ready;
                out_data  = in_data;
            end
            ST_TRL: begin
                out_valid = 1'b1;
                out_last  = (cnt == trl_last);
                out_data  = is_ctrl ? 8'(crc16_fin >> {cnt[0], 3'b000})
                                    : 8'(crc32_fin >> {cnt[1:0], 3'b000});
            end
            default: ;
        endcase
    end

    assign crc_init = desc_valid && desc_ready;
    assign crc_upd  = fire && (state != ST_TRL);

    // R8: stalled non-payload byte stays valid and stable
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && state != ST_PAY) |=> (out_valid && $stable(out_data)));

    // R9: after the last byte transfers, the block is idle again
    a_r9_last_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last && out_ready) |=> desc_ready);

    // R7: trailer counter never passes the trailer length
    a_r7_trl_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRL) |-> (cnt <= trl_last));

    // R10: payload input closed outside payload phase
    a_r10_in_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_PAY) |-> !in_ready);

endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
    import framer_pkg::*;
#(
    parameter int ALIGN_BYTES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        desc_valid,
    output logic        desc_ready,
    input  logic [7:0]  desc_version,
    input  logic [7:0]  desc_type,
    input  logic [15:0] desc_len,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data,
    output logic        out_last
);

    logic [31:0] crc32_fin;
    logic [15:0] crc16_fin;
    logic        crc_init;
    logic        crc_upd;

    framer_ctrl #(.ALIGN_BYTES(ALIGN_BYTES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .desc_valid   (desc_valid),
        .desc_version (desc_version),
        .desc_type    (desc_type),
        .desc_len     (desc_len),
        .desc_ready   (desc_ready),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .out_ready    (out_ready),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_last     (out_last),
        .crc32_fin    (crc32_fin),
        .crc16_fin    (crc16_fin),
        .crc_init     (crc_init),
        .crc_upd      (crc_upd)
    );

    framer_crc u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (crc_init),
        .upd       (crc_upd),
        .din       (out_data),
        .crc32_fin (crc32_fin),
        .crc16_fin (crc16_fin)
    );

endmodule

// File: tb/test_pkt_framer.sv
module test_pkt_framer;

    localparam int ALIGN = 8;
    localparam int PADN  = (ALIGN - (4 % ALIGN)) % ALIGN;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_valid = 1'b0;
    logic        desc_ready;
    logic [7:0]  desc_version = '0;
    logic [7:0]  desc_type = '0;
    logic [15:0] desc_len = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        out_last;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [7:0] pay   [0:511];
    logic [7:0] exp_b [0:1023];
    int         exp_n;
    int         pay_lo, pay_hi;

    always #4 clk = ~clk;

    pkt_framer #(.ALIGN_BYTES(ALIGN)) i_pkt_framer (
        .clk(clk), .rst_n(rst_n),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_version(desc_version), .desc_type(desc_type), .desc_len(desc_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Bit-serial models, one input bit at a time
    function automatic logic [31:0] m_crc32(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++) begin
                logic fb = c[0] ^ exp_b[i][b];
                c = c >> 1;
                if (fb) c = c ^ 32'h82F6_3B78;
            end
        return ~c;
    endfunction

    function automatic logic [15:0] m_crc16(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++) begin
                logic fb = c[0] ^ exp_b[i][b];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        return ~c;
    endfunction

    task automatic build(input logic [7:0] v, input logic [7:0] t, input int len);
        int n = 0;
        exp_b[n++] = v;
        exp_b[n++] = t;
        exp_b[n++] = 8'(len >> 8);
        exp_b[n++] = 8'(len);
        for (int i = 0; i < PADN; i++) exp_b[n++] = 8'h00;
        pay_lo = n;
        for (int i = 0; i < len; i++) exp_b[n++] = pay[i];
        pay_hi = n;
        if (t[7]) begin
            logic [15:0] c = m_crc16(n);
            exp_b[n++] = c[7:0];
            exp_b[n++] = c[15:8];
        end else begin
            logic [31:0] c = m_crc32(n);
            exp_b[n++] = c[7:0];
            exp_b[n++] = c[15:8];
            exp_b[n++] = c[23:16];
            exp_b[n++] = c[31:24];
        end
        exp_n = n;
    endtask

    function automatic string tag_of(input int idx, input bit ctl);
        if (idx < 4) return "R2";
        if (idx < pay_lo) return "R3";
        if (idx < pay_hi) return "R4";
        return ctl ? "R6" : "R5";
    endfunction

    task automatic run_pkt(input logic [7:0] v, input logic [7:0] t, input int len);
        for (int i = 0; i < len; i++) pay[i] = 8'($urandom);
        build(v, t, len);
        @(negedge clk);
        desc_valid = 1'b1; desc_version = v; desc_type = t; desc_len = 16'(len);
        #1;
        while (!desc_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        desc_valid = 1'b0;
        desc_version = 8'($urandom); desc_type = 8'($urandom); desc_len = 16'($urandom);
        #1;
        check(desc_ready == 1'b0, "R9 busy", 32'(desc_ready), 0);
        fork
            begin : src
                int k = 0;
                while (k < len) begin
                    @(negedge clk);
                    in_valid = ($urandom % 4) != 0;
                    in_data  = pay[k];
                    #1;
                    if (in_valid && in_ready) k++;
                end
                @(negedge clk);
                in_valid = 1'b0;
            end
            begin : snk
                int idx = 0;
                bit stalled = 0;
                logic [7:0] held = 0;
                while (idx < exp_n) begin
                    @(negedge clk);
                    out_ready = ($urandom % 3) != 0;
                    #1;
                    if (stalled) begin
                        check(out_valid && out_data == held, "R8 hold", {23'h0, out_valid, out_data}, {24'h1, held});
                    end
                    if (!out_ready) check(!in_ready, "R8 in_ready", 32'(in_ready), 0);
                    if (idx < pay_lo || idx >= pay_hi) check(!in_ready, "R10", 32'(in_ready), 0);
                    stalled = out_valid && !out_ready && (idx < pay_lo || idx >= pay_hi);
                    held = out_data;
                    if (out_valid && out_ready) begin
                        check(out_data == exp_b[idx], tag_of(idx, t[7]), 32'(out_data), 32'(exp_b[idx]));
                        check(out_last == (idx == exp_n - 1), "R7", 32'(out_last), 32'(idx == exp_n - 1));
                        idx++;
                    end
                end
                @(negedge clk);
                out_ready = 1'b0;
                #1;
                check(desc_ready == 1'b1, "R9 idle", 32'(desc_ready), 1);
                check(out_valid == 1'b0, "R9 no output", 32'(out_valid), 0);
            end
        join
    endtask

    initial begin
        void'($urandom(32'h0000_5EED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(desc_ready == 1'b1, "R1 desc_ready", 32'(desc_ready), 1);
        check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
        check(out_last == 1'b0, "R1 out_last", 32'(out_last), 0);
        check(in_ready == 1'b0, "R1 in_ready", 32'(in_ready), 0);

        // Directed corners: empty data, empty control, single byte, long control
        run_pkt(8'h01, 8'h05, 0);    // R4 R5 zero length
        run_pkt(8'h02, 8'h81, 0);    // R4 R6 zero length
        run_pkt(8'hA5, 8'h10, 1);    // R4 R5
        run_pkt(8'h3C, 8'hFF, 300);  // R2 high length byte, R6
        run_pkt(8'h00, 8'h7F, 257);  // R5 long data

        for (int p = 0; p < 24; p++)
            run_pkt(8'($urandom), 8'($urandom), int'($urandom % 48));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule